// File: doc/BRIEF.md
# Bit-Test Decision Tree Channel Lookup

This block turns a 12-bit peripheral identifier into an 8-bit channel index. The identifier is the 4-bit slave number placed above the 8-bit peripheral number. The mapping is held as a binary decision tree in a 256-entry table. Each table word names one bit of the identifier to examine. For each value of that bit, the word gives either a link to another table word or a final index. A lookup starts at word 0, takes one branch per visited word, and ends with an index. It ends instead with a not-found flag if no final index has been reached after 16 visits.

The host loads table words through a plain write port. Reading the table store costs `FETCH_LAT` wait cycles, so the block keeps a per-word cached copy with a valid bit. A visit to a cached word takes one cycle, and a visit to an uncached word takes `FETCH_LAT + 1` cycles and fills the cache. Writing a word clears its valid bit, so the next visit fetches the new contents.

Requests and responses use valid/ready handshakes. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The source must hold `req_valid`, `req_sid` and `req_per` stable until then. Only one lookup is in flight at a time: `req_ready` is high only while the block is idle. A response is presented with `rsp_valid`, and `rsp_index` and `rsp_miss` stay unchanged until the edge where `rsp_ready` is high. The block is idle again in the following cycle.

Top module: `bittree_lookup`

## Requirements
- R1: A request is accepted on an edge with `req_valid` and `req_ready` high. `req_ready` is high only when no lookup is in progress, and it is low from the cycle after acceptance until the response has been taken. The identifier used is `{req_sid, req_per}`, with the slave number in bits 11:8.
- R2: Each table word is decoded as follows:
  - Bits 21:18 name the identifier bit to test. A named bit position of 12 to 15 reads as 0.
  - For a tested value of 0: bit 17 set means bits 16:9 link to the next word; bit 17 clear means bits 16:9 are the result.
  - For a tested value of 1: bit 8 set means bits 7:0 link to the next word; bit 8 clear means bits 7:0 are the result.
  - Bits 31:22 are ignored.
- R3: Every lookup starts its walk at table word 0.
- R4: A lookup visits at most 16 words. If the 16th visited word still selects a link, the response has `rsp_miss` = 1 and `rsp_index` = 0. A result found on the 16th visit is reported normally with `rsp_miss` = 0.
- R5: A visit to a word whose cached copy is valid takes one cycle. A visit to a word without a valid copy takes `FETCH_LAT` + 1 cycles, after which that word's copy is valid. From the acceptance edge, `rsp_valid` rises after the sum of the visit costs.
- R6: A table write clears the cached copy of the written word, so the next visit to that word fetches the new contents. If the write lands on the same edge as that word's fill, the walk uses the contents from before the write and the word stays invalid.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_index` and `rsp_miss` hold their values. After the edge with `rsp_ready` high, `rsp_valid` is low and `req_ready` is high.
- R8: After reset, `req_ready` = 1, `rsp_valid` = 0 and every cached copy is invalid. Reset leaves the table contents in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_sid | input | 4 | Slave number, identifier bits 11:8 |
| req_per | input | 8 | Peripheral number, identifier bits 7:0 |
| rsp_valid | output | 1 | Lookup response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_index | output | 8 | Channel index found (0 on miss) |
| rsp_miss | output | 1 | No result within 16 visits |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | 8 | Table word written |
| tbl_wr_data | input | 32 | Table word contents |

## Verification
The table write port and the tree walk can both act on the same word in one cycle. The interesting case is a write to the word whose fetch is completing and being decoded in that cycle.

A directed case times a write to word 0 to the exact edge on which its fill lands. The response must carry the old result, and the next lookup must pay the fetch cost again and return the new result. A long random phase then aims writes at a handful of low table words while walks through those words are in progress and responses are back-pressured. A behavioural model in the bench decides the outcome of every collision and is compared with the outputs on every clock.

// File: rtl/btl_pkg.sv
package btl_pkg;

  // Index and link values held in a table word
  localparam int NODE_W    = 8;
  // Identifier bit selector
  localparam int SEL_W     = 4;
  localparam int SEL_SPAN  = 1 << SEL_W;
  // Low part of a table word that carries meaning; upper bits are dropped
  localparam int KEEP_W    = SEL_W + 2 * (NODE_W + 1);
  localparam int SEL_LSB   = 2 * (NODE_W + 1);
  localparam int ZLINK_BIT = 2 * NODE_W + 1;
  localparam int ZVAL_LSB  = NODE_W + 1;
  localparam int OLINK_BIT = NODE_W;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic              zero_link;
    logic [NODE_W-1:0] zero_val;
    logic              one_link;
    logic [NODE_W-1:0] one_val;
  } node_word_t;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_WALK = 2'd1,
    WS_RESP = 2'd2
  } walk_state_e;

endpackage

// File: rtl/btl_store.sv
module btl_store #(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 22,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_word;
  end

  // Read returns contents as they stand before any write on this edge
  assign rd_word = mem_q[rd_addr];

endmodule

// File: rtl/btl_cache.sv
module btl_cache #(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 22,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     lk_addr,
  output logic              lk_hit,
  output logic [WORD_W-1:0] lk_word,
  input  logic              fill_en,
  input  logic [AW-1:0]     fill_addr,
  input  logic [WORD_W-1:0] fill_word,
  input  logic              inv_en,
  input  logic [AW-1:0]     inv_addr
);

  logic [DEPTH-1:0]  vld_q;
  logic [WORD_W-1:0] dat_q [DEPTH];

  always_ff @(posedge clk) begin
    if (fill_en) dat_q[fill_addr] <= fill_word;
  end

  // Per-word valid flag: an invalidate outranks a fill on the same edge
  for (genvar g = 0; g < DEPTH; g++) begin : g_vld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        vld_q[g] <= 1'b0;
      else if (inv_en && (inv_addr == AW'(g)))
        vld_q[g] <= 1'b0;
      else if (fill_en && (fill_addr == AW'(g)))
        vld_q[g] <= 1'b1;
    end
  end

  assign lk_hit  = vld_q[lk_addr];
  assign lk_word = dat_q[lk_addr];

  AST_INV_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> !vld_q[$past(inv_addr)]) else $error("written word left valid"); // R6

  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !(inv_en && (inv_addr == fill_addr))) |=> vld_q[$past(fill_addr)])
    else $error("fill did not validate word"); // R5

endmodule

// File: rtl/btl_node_dec.sv
module btl_node_dec
  import btl_pkg::*;
#(
  parameter int ID_W = 12
) (
  input  logic [KEEP_W-1:0] word,
  input  logic [ID_W-1:0]   id,
  output logic              is_link,
  output logic [NODE_W-1:0] value
);

  node_word_t       nw;
  logic [SEL_SPAN-1:0] id_ext;
  logic             tested;

  assign nw     = node_word_t'(word);
  // Selector positions beyond the identifier width read as zero
  assign id_ext = SEL_SPAN'(id);
  assign tested = id_ext[nw.sel];

  always_comb begin
    if (tested) begin
      is_link = nw.one_link;
      value   = nw.one_val;
    end else begin
      is_link = nw.zero_link;
      value   = nw.zero_val;
    end
  end

endmodule

// File: rtl/btl_walker.sv
module btl_walker
  import btl_pkg::*;
#(
  parameter int ID_W      = 12,
  parameter int MAX_DEPTH = 16,
  parameter int FETCH_LAT = 2,
  localparam int VIS_W    = $clog2(MAX_DEPTH + 1),
  localparam int WAIT_W   = $clog2(FETCH_LAT + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [NODE_W-1:0] rsp_index,
  output logic              rsp_miss,
  output logic [NODE_W-1:0] node_addr,
  input  logic              ent_hit,
  input  logic [KEEP_W-1:0] cache_word,
  input  logic [KEEP_W-1:0] store_word,
  output logic              fill_en,
  output logic [KEEP_W-1:0] fill_word
);

  walk_state_e       st_q;
  logic [ID_W-1:0]   id_q;
  logic [NODE_W-1:0] node_q;
  logic [VIS_W-1:0]  vis_q;
  logic [WAIT_W-1:0] wait_q;
  logic [NODE_W-1:0] res_q;
  logic              miss_q;

  logic [KEEP_W-1:0] ent_word;
  logic              fetch_ready;
  logic              step;
  logic              last_visit;
  logic              dec_link;
  logic [NODE_W-1:0] dec_val;

  assign ent_word    = ent_hit ? cache_word : store_word;
  assign fetch_ready = ent_hit || (wait_q == WAIT_W'(FETCH_LAT));
  assign step        = (st_q == WS_WALK) && fetch_ready;
  assign last_visit  = (vis_q == VIS_W'(MAX_DEPTH - 1));

  btl_node_dec #(.ID_W(ID_W)) u_dec (
    .word    (ent_word),
    .id      (id_q),
    .is_link (dec_link),
    .value   (dec_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WS_IDLE;
      id_q   <= '0;
      node_q <= '0;
      vis_q  <= '0;
      wait_q <= '0;
      res_q  <= '0;
      miss_q <= 1'b0;
    end else begin
      unique case (st_q)
        WS_IDLE: begin
          if (req_valid) begin
            id_q   <= req_id;
            node_q <= '0;
            vis_q  <= '0;
            wait_q <= '0;
            st_q   <= WS_WALK;
          end
        end
        WS_WALK: begin
          if (!fetch_ready) begin
            wait_q <= wait_q + 1'b1;
          end else begin
            wait_q <= '0;
            vis_q  <= vis_q + 1'b1;
            if (!dec_link) begin
              res_q  <= dec_val;
              miss_q <= 1'b0;
              st_q   <= WS_RESP;
            end else if (last_visit) begin
              res_q  <= '0;
              miss_q <= 1'b1;
              st_q   <= WS_RESP;
            end else begin
              node_q <= dec_val;
            end
          end
        end
        WS_RESP: begin
          if (rsp_ready) st_q <= WS_IDLE;
        end
        default: st_q <= WS_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == WS_IDLE);
  assign rsp_valid = (st_q == WS_RESP);
  assign rsp_index = res_q;
  assign rsp_miss  = miss_q;
  assign node_addr = node_q;
  assign fill_en   = step && !ent_hit;
  assign fill_word = store_word;

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready) else $error("second request taken"); // R1

  AST_MISS_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (vis_q == VIS_W'(MAX_DEPTH)))
    else $error("miss before depth limit"); // R4

  AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == WS_WALK) && ent_hit) |=> (vis_q == VIS_W'($past(vis_q) + 1'b1)))
    else $error("cached visit not single cycle"); // R5

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_index) && $stable(rsp_miss)))
    else $error("response changed under back-pressure"); // R7

endmodule

// File: rtl/bittree_lookup.sv
module bittree_lookup
  import btl_pkg::*;
#(
  parameter int SID_W     = 4,
  parameter int PER_W     = 8,
  parameter int MAX_DEPTH = 16,
  parameter int FETCH_LAT = 2,
  parameter int TBL_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SID_W-1:0]  req_sid,
  input  logic [PER_W-1:0]  req_per,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [NODE_W-1:0] rsp_index,
  output logic              rsp_miss,
  input  logic              tbl_wr_en,
  input  logic [NODE_W-1:0] tbl_wr_addr,
  input  logic [TBL_W-1:0]  tbl_wr_data
);

  localparam int ID_W      = SID_W + PER_W;
  localparam int TBL_DEPTH = 1 << NODE_W;

  logic [ID_W-1:0]   req_id;
  logic [KEEP_W-1:0] wr_keep;
  logic              unused_hi;
  logic [NODE_W-1:0] node_addr;
  logic              ent_hit;
  logic [KEEP_W-1:0] cache_word;
  logic [KEEP_W-1:0] store_word;
  logic              fill_en;
  logic [KEEP_W-1:0] fill_word;

  assign req_id    = {req_sid, req_per};
  assign wr_keep   = tbl_wr_data[KEEP_W-1:0];
  assign unused_hi = ^tbl_wr_data[TBL_W-1:KEEP_W];

  btl_store #(.DEPTH(TBL_DEPTH), .WORD_W(KEEP_W)) u_store (
    .clk     (clk),
    .wr_en   (tbl_wr_en),
    .wr_addr (tbl_wr_addr),
    .wr_word (wr_keep),
    .rd_addr (node_addr),
    .rd_word (store_word)
  );

  btl_cache #(.DEPTH(TBL_DEPTH), .WORD_W(KEEP_W)) u_cache (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_addr   (node_addr),
    .lk_hit    (ent_hit),
    .lk_word   (cache_word),
    .fill_en   (fill_en),
    .fill_addr (node_addr),
    .fill_word (fill_word),
    .inv_en    (tbl_wr_en),
    .inv_addr  (tbl_wr_addr)
  );

  btl_walker #(
    .ID_W      (ID_W),
    .MAX_DEPTH (MAX_DEPTH),
    .FETCH_LAT (FETCH_LAT)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_id     (req_id),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_index  (rsp_index),
    .rsp_miss   (rsp_miss),
    .node_addr  (node_addr),
    .ent_hit    (ent_hit),
    .cache_word (cache_word),
    .store_word (store_word),
    .fill_en    (fill_en),
    .fill_word  (fill_word)
  );

endmodule

// File: tb/sim_bittree_lookup.sv
module sim_bittree_lookup;

  localparam int FL = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_sid = '0;
  logic [7:0]  req_per = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [7:0]  rsp_index;
  logic        rsp_miss;
  logic        tbl_wr_en = 1'b0;
  logic [7:0]  tbl_wr_addr = '0;
  logic [31:0] tbl_wr_data = '0;

  int vec_n = 0;
  int bad_n = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bittree_lookup #(.FETCH_LAT(FL)) u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_sid, .req_per,
    .rsp_valid, .rsp_ready, .rsp_index, .rsp_miss,
    .tbl_wr_en, .tbl_wr_addr, .tbl_wr_data
  );

  function automatic logic [31:0] mk(int sel, int zl, int zv, int ol, int ov);
    return 32'((sel & 15) << 18 | (zl & 1) << 17 | (zv & 255) << 9 | (ol & 1) << 8 | (ov & 255));
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    vec_n++;
    if (act != exp) begin
      bad_n++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_mem [256];
  bit m_cv  [256];
  int m_cd  [256];
  int m_state = 0;   // 0 idle, 1 walking, 2 answering
  int m_id, m_node, m_vis, m_wait, m_res;
  bit m_miss;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0;
      foreach (m_cv[i]) m_cv[i] = 0;
    end else begin
      case (m_state)
        0: if (req_valid) begin
             m_id = {req_sid, req_per};
             m_node = 0; m_vis = 0; m_wait = 0; m_state = 1;
           end
        1: begin
             bit hit;
             hit = m_cv[m_node];
             if (!hit && m_wait < FL) m_wait++;
             else begin
               int e, s, b, lk, v;
               e = hit ? m_cd[m_node] : m_mem[m_node];
               if (!hit) begin m_cv[m_node] = 1; m_cd[m_node] = e; end
               m_wait = 0;
               m_vis++;
               s = (e >> 18) & 15;
               b = (s < 12) ? ((m_id >> s) & 1) : 0;
               lk = b ? ((e >> 8) & 1) : ((e >> 17) & 1);
               v  = b ? (e & 255) : ((e >> 9) & 255);
               if (!lk) begin m_res = v; m_miss = 0; m_state = 2; end
               else if (m_vis == 16) begin m_res = 0; m_miss = 1; m_state = 2; end
               else m_node = v;
             end
           end
        default: if (rsp_ready) m_state = 0;
      endcase
      if (tbl_wr_en) begin
        m_mem[tbl_wr_addr] = int'(tbl_wr_data[21:0]);
        m_cv[tbl_wr_addr] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1 req_ready", req_ready, m_state == 0);
      chk("R7 rsp_valid", rsp_valid, m_state == 2);
      if (rsp_valid && m_state == 2) begin
        chk(m_miss ? "R4 rsp_index" : "R2 rsp_index", rsp_index, m_res);
        chk(m_miss ? "R4 rsp_miss" : "R2 rsp_miss", rsp_miss, m_miss);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input logic [31:0] d);
    tbl_wr_en = 1; tbl_wr_addr = 8'(a); tbl_wr_data = d;
    @(negedge clk);
    tbl_wr_en = 0;
  endtask

  task automatic lookup(input int sid, input int per, input int hold,
                        output int idx, output int miss, output int lat);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_sid = 4'(sid); req_per = 8'(per);
    lat = 0;
    do begin
      @(negedge clk);
      if (lat == 0) chk("R1 busy after accept", req_ready, 0);
      req_valid = 0;
      lat++;
    end while (!rsp_valid);
    idx = rsp_index; miss = rsp_miss;
    repeat (hold) begin
      @(negedge clk);
      chk("R7 held index", rsp_index, idx);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk("R7 idle after take", req_ready, 1);
  endtask

  // ---------------- directed and random sequences ----------------
  initial begin
    int idx, miss, lat;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 ready after reset", req_ready, 1);
    chk("R8 no rsp after reset", rsp_valid, 0);
    for (int i = 0; i < 256; i++) wr(i, mk(0, 0, i, 0, i));

    // R3 walk from word 0, R2 decode of both branches
    wr(0, mk(11, 1, 1, 0, 8'hA5));
    wr(1, mk(0, 0, 8'h11, 0, 8'h22));
    lookup(8, 8'h00, 0, idx, miss, lat);
    chk("R3 root result", idx, 8'hA5);
    chk("R5 miss latency", lat, 1 + (FL + 1));
    lookup(8, 8'h3C, 0, idx, miss, lat);
    chk("R5 hit latency", lat, 2);
    lookup(0, 8'h00, 0, idx, miss, lat);
    chk("R2 zero branch", idx, 8'h11);
    chk("R5 mixed latency", lat, 1 + 1 + (FL + 1));
    lookup(0, 8'h01, 3, idx, miss, lat);
    chk("R2 one branch", idx, 8'h22);
    chk("R7 held result", idx, 8'h22);

    // R2 selector beyond identifier width, R6 rewrite refetch
    wr(1, mk(14, 0, 8'h5A, 0, 8'hC3));
    lookup(0, 8'hFF, 0, idx, miss, lat);
    chk("R2 high selector reads 0", idx, 8'h5A);
    chk("R6 refetch after write", lat, 1 + 1 + (FL + 1));

    // R6 write on the fill edge of word 0
    wr(0, mk(11, 1, 1, 0, 8'hA5));
    fork
      lookup(8, 8'h00, 0, idx, miss, lat);
      begin
        repeat (FL + 1) @(negedge clk);
        wr(0, mk(11, 0, 8'h77, 0, 8'h66));
      end
    join
    chk("R6 old contents used", idx, 8'hA5);
    lookup(8, 8'h00, 0, idx, miss, lat);
    chk("R6 new contents", idx, 8'h66);
    chk("R6 word stayed invalid", lat, 1 + (FL + 1));

    // R4 depth limit: sixteen visits
    for (int i = 0; i < 15; i++) wr(i, mk(0, 1, i + 1, 1, i + 1));
    wr(15, mk(0, 0, 8'hE1, 0, 8'hE1));
    lookup(0, 0, 0, idx, miss, lat);
    chk("R4 result on 16th visit", idx, 8'hE1);
    chk("R4 found flag", miss, 0);
    chk("R5 chain all miss", lat, 1 + 16 * (FL + 1));
    lookup(0, 0, 0, idx, miss, lat);
    chk("R5 chain all hit", lat, 17);
    wr(15, mk(0, 1, 16, 1, 16));
    lookup(0, 0, 2, idx, miss, lat);
    chk("R4 miss flag", miss, 1);
    chk("R4 miss index", idx, 0);
    chk("R4 stops at 16", lat, 1 + 15 + (FL + 1));

    // R8 reset drops the cache but keeps the table
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R8 ready after mid reset", req_ready, 1);
    chk("R8 rsp low after mid reset", rsp_valid, 0);
    lookup(0, 0, 0, idx, miss, lat);
    chk("R8 cache cleared", lat, 1 + 16 * (FL + 1));
    chk("R8 table kept", miss, 1);

    // Random: collisions of writes with walks, back-pressure
    begin
      bit pend = 0;
      for (int c = 0; c < 6000; c++) begin
        if (pend) begin req_valid = 0; pend = 0; end
        if (!req_valid && ($urandom % 3 == 0)) begin
          req_valid = 1; req_sid = 4'($urandom); req_per = 8'($urandom);
        end
        if (req_valid && req_ready) pend = 1;
        rsp_ready = ($urandom % 3 != 0);
        tbl_wr_en = ($urandom % 4 == 0);
        tbl_wr_addr = 8'($urandom % 8);
        tbl_wr_data = {10'($urandom), 22'(mk($urandom % 16, $urandom % 2, $urandom % 8,
                                            $urandom % 2, $urandom % 8))};
        @(negedge clk);
      end
      req_valid = 0; tbl_wr_en = 0; rsp_ready = 1;
      repeat (80) @(negedge clk);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad_n++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
      $finish;
    end
  end

endmodule